// File: doc/BRIEF.md
# DSI Direct Command Sequencer

This block sends one low-level command packet to a display: a short or long write, a read request, a tearing-effect or trigger request, or a turnaround request that expects an acknowledge. Software first writes a settings word that gives the command kind, payload size, virtual channel, data type, packet length class and low-power flag. It then pushes payload words into a small command FIFO and writes the send register. The engine puts the packet out one byte at a time over a valid/ready handshake. It reports the outcome through a status vector.

For a read, the engine waits after transmission for reply bytes on a byte input with valid, last and error flags. It packs those bytes four to a 32-bit word, little-endian, into a receive FIFO that software drains with a pop strobe. For an acknowledge request, the reply only decides which acknowledge flag is set. ECC, checksums and the lane layer sit outside this block. The ECC position in the header is filled with zero.

Top module: `dsi_cmd_engine`

## Requirements
- R1: After reset the status vector is all zero, txValid is low and rdWordValid is low.
- R2: Register addresses on regAddr are 0 settings, 1 payload push, 2 send and 3 command-FIFO flush. The settings word holds the low-power flag in bit 24, the payload byte count in bits 23..16, the virtual channel in bits 15..14, the data type in bits 13..8, the long-packet flag in bit 3 and the command kind in bits 2..0. The kind codes are 0 write, 1 read, 4 tearing-effect request, 5 trigger request and 6 acknowledge request.
- R3: Every packet starts with four bytes. The first is {channel, data type}. The next two are the byte count (low byte, then a zero high byte) for a long packet, or the first two payload bytes for a short packet. The fourth is 0x00.
- R4: A long packet is followed by exactly the byte-count payload bytes, taken four per pushed word with the first byte in bits 7..0. Byte positions not covered by a pushed word go out as 0x00.
- R5: The cycle after an accepted send, status bit 0 is set, every completion bit is clear, and txValid is high with the first header byte.
- R6: A write completes on the edge that hands over its last byte: status bit 1 sets and bit 0 clears. A tearing-effect or trigger request completes the same way but sets bit 2.
- R7: After its bytes go out, a read collects reply bytes until rxLast and then sets status bit 3, or bit 10 if rxErr is high with the last byte. Reply bytes are packed little-endian into words. A final partial word is zero-filled, and words beyond the RX_WORDS capacity are dropped.
- R8: After its bytes go out, an acknowledge request waits for a reply byte with rxLast and then sets status bit 4, or bit 5 if rxErr is high. It stores no reply data.
- R9: A send is rejected if the byte count exceeds the command FIFO capacity of 4*2^DEPTH_CODE bytes, if a read asks for more than 2 payload bytes, or if the kind code is 2, 3 or 7. A rejected send transmits nothing and leaves status unchanged.
- R10: While status bit 0 is set, writes to the send, settings, push and flush registers have no effect.
- R11: A write to the flush register empties the command FIFO. Pushes beyond capacity are dropped. A completed transmission also empties the FIFO.
- R12: txLp equals the settings low-power flag, and txByte and txLp hold steady while txValid waits for txReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Register write data |
| txByte | output | 8 | Outgoing packet byte |
| txValid | output | 1 | Outgoing byte valid |
| txReady | input | 1 | Sink accepts the byte |
| txLp | output | 1 | Low-power transmission request for the current packet |
| rxByte | input | 8 | Reply byte |
| rxValid | input | 1 | Reply byte valid |
| rxLast | input | 1 | Final reply byte |
| rxErr | input | 1 | Reply reported an error (sampled with rxLast) |
| status | output | 11 | Busy and completion flags |
| rdWord | output | 32 | Oldest received word |
| rdWordValid | output | 1 | Receive FIFO not empty |
| rdPop | input | 1 | Remove the oldest received word |

## Verification
The send write is registered, so status bit 0 and the first header byte appear one cycle after the edge that takes the send. The completion bit rises on the same edge that hands over the last byte or takes the last reply byte. A received word becomes visible one cycle after the byte that fills it. The bench drives inputs on falling edges and samples on falling edges after the relevant rising edge. It records each byte on the rising edge that accepts it, so random backpressure changes when a result arrives but never whether it is correct.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;

  localparam logic [1:0] ADDR_SETTINGS = 2'd0;
  localparam logic [1:0] ADDR_PUSH     = 2'd1;
  localparam logic [1:0] ADDR_SEND     = 2'd2;
  localparam logic [1:0] ADDR_FLUSH    = 2'd3;

  localparam logic [2:0] KIND_WRITE = 3'd0;
  localparam logic [2:0] KIND_READ  = 3'd1;
  localparam logic [2:0] KIND_TE    = 3'd4;
  localparam logic [2:0] KIND_TRIG  = 3'd5;
  localparam logic [2:0] KIND_ACK   = 3'd6;

  localparam int STATUS_W    = 11;
  localparam int ST_BUSY     = 0;
  localparam int ST_WR_DONE  = 1;
  localparam int ST_TRG_DONE = 2;
  localparam int ST_RD_DONE  = 3;
  localparam int ST_ACK      = 4;
  localparam int ST_ACK_ERR  = 5;
  localparam int ST_RD_ERR   = 10;

  typedef struct packed {
    logic       lowPower;
    logic [7:0] size;
    logic [1:0] vc;
    logic [5:0] dataType;
    logic       isLong;
    logic [2:0] kind;
  } cmdSettings_t;

  // strobes from control to datapath
  typedef struct packed {
    logic beginCmd;
    logic dropCmd;
    logic rxTake;
    logic setWrDone;
    logic setTrigDone;
    logic setRdDone;
    logic setRdErr;
    logic setAck;
    logic setAckErr;
  } ctlStrobe_t;

  function automatic cmdSettings_t unpackSettings(input logic [31:0] w);
    cmdSettings_t s;
    s.lowPower = w[24];
    s.size     = w[23:16];
    s.vc       = w[15:14];
    s.dataType = w[13:8];
    s.isLong   = w[3];
    s.kind     = w[2:0];
    return s;
  endfunction

endpackage

// File: rtl/dsi_cmd_ctrl.sv
module dsi_cmd_ctrl
  import dsi_cmd_pkg::*;
#(
  parameter int CMD_BYTES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sendReq,
  input  logic [2:0] cfgKind,
  input  logic [7:0] cfgSize,
  input  logic       cfgLong,
  input  logic       txReady,
  input  logic       rxValid,
  input  logic       rxLast,
  input  logic       rxErr,
  output ctlStrobe_t stb,
  output logic       txValid,
  output logic       busy,
  output logic [8:0] byteIdx
);

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} state_e;

  state_e     state, stateNext;
  logic [8:0] idxNext;
  logic [8:0] lastIdx;
  logic       kindKnown;
  logic       sizeFits;
  logic       readFits;
  logic       cmdLegal;

  always_comb begin
    kindKnown = (cfgKind == KIND_WRITE) || (cfgKind == KIND_READ) ||
                (cfgKind == KIND_TE) || (cfgKind == KIND_TRIG) ||
                (cfgKind == KIND_ACK);
    sizeFits  = int'({24'd0, cfgSize}) <= CMD_BYTES;
    readFits  = !((cfgKind == KIND_READ) && (cfgSize > 8'd2));
    cmdLegal  = kindKnown && sizeFits && readFits;
    lastIdx   = cfgLong ? ({1'b0, cfgSize} + 9'd3) : 9'd3;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    idxNext   = byteIdx;
    unique case (state)
      ST_IDLE: begin
        if (sendReq && cmdLegal) begin
          stb.beginCmd = 1'b1;
          stateNext    = ST_TX;
          idxNext      = 9'd0;
        end
      end
      ST_TX: begin
        if (txReady) begin
          if (byteIdx == lastIdx) begin
            stb.dropCmd = 1'b1;
            if (cfgKind == KIND_WRITE) begin
              stb.setWrDone = 1'b1;
              stateNext     = ST_IDLE;
            end else if ((cfgKind == KIND_TE) || (cfgKind == KIND_TRIG)) begin
              stb.setTrigDone = 1'b1;
              stateNext       = ST_IDLE;
            end else begin
              stateNext = ST_RX;
            end
          end else begin
            idxNext = byteIdx + 9'd1;
          end
        end
      end
      ST_RX: begin
        if (rxValid) begin
          stb.rxTake = (cfgKind == KIND_READ);
          if (rxLast) begin
            stateNext = ST_IDLE;
            if (cfgKind == KIND_READ) begin
              stb.setRdErr  = rxErr;
              stb.setRdDone = !rxErr;
            end else begin
              stb.setAckErr = rxErr;
              stb.setAck    = !rxErr;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= 9'd0;
    end else begin
      state   <= stateNext;
      byteIdx <= idxNext;
    end
  end

  assign txValid = (state == ST_TX);
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/dsi_cmd_datapath.sv
module dsi_cmd_datapath
  import dsi_cmd_pkg::*;
#(
  parameter int CMD_WORDS = 2,
  parameter int RX_WORDS  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [31:0]         regWdata,
  input  logic                busy,
  input  logic [8:0]          byteIdx,
  input  ctlStrobe_t          stb,
  input  logic [7:0]          rxByte,
  input  logic                rxLast,
  input  logic                rdPop,
  output cmdSettings_t        cfg,
  output logic                sendReq,
  output logic [7:0]          txByte,
  output logic                txLp,
  output logic [STATUS_W-1:0] status,
  output logic [31:0]         rdWord,
  output logic                rdWordValid
);

  localparam int CIW = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;
  localparam int CCW = $clog2(CMD_WORDS + 1);
  localparam int RIW = (RX_WORDS > 1) ? $clog2(RX_WORDS) : 1;
  localparam int RCW = $clog2(RX_WORDS + 1);
  localparam logic [CCW-1:0] CMD_FULL = CCW'(CMD_WORDS);
  localparam logic [RCW-1:0] RX_FULL  = RCW'(RX_WORDS);
  localparam logic [RIW-1:0] RX_LAST  = RIW'(RX_WORDS - 1);

  // register decode
  logic wrSettings, wrPush, wrFlush;
  always_comb begin
    sendReq    = regWe && (regAddr == ADDR_SEND);
    wrSettings = regWe && (regAddr == ADDR_SETTINGS) && !busy;
    wrPush     = regWe && (regAddr == ADDR_PUSH) && !busy;
    wrFlush    = regWe && (regAddr == ADDR_FLUSH) && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfg <= '0;
    else if (wrSettings) cfg <= unpackSettings(regWdata);
  end

  // command payload FIFO
  logic [31:0]    cmdMem [CMD_WORDS];
  logic [CCW-1:0] cmdCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCount <= '0;
    end else if (wrFlush || stb.dropCmd) begin
      cmdCount <= '0;
    end else if (wrPush && (cmdCount != CMD_FULL)) begin
      cmdCount <= cmdCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrPush && (cmdCount != CMD_FULL)) cmdMem[cmdCount[CIW-1:0]] <= regWdata;
  end

  // outgoing byte selection
  logic [8:0] fetchIdx;
  logic [6:0] fetchWord;
  logic       fetchOk;
  logic [7:0] fetchByte;
  logic [31:0] fetchData;

  always_comb begin
    if (byteIdx >= 9'd4)      fetchIdx = byteIdx - 9'd4;
    else if (byteIdx == 9'd2) fetchIdx = 9'd1;
    else                      fetchIdx = 9'd0;
    fetchWord = fetchIdx[8:2];
    fetchOk   = 9'(fetchWord) < 9'(cmdCount);
    fetchData = cmdMem[fetchWord[CIW-1:0]];
    fetchByte = fetchOk ? fetchData[{fetchIdx[1:0], 3'b000} +: 8] : 8'd0;
  end

  always_comb begin
    unique case (byteIdx)
      9'd0:    txByte = {cfg.vc, cfg.dataType};
      9'd1:    txByte = cfg.isLong ? cfg.size : fetchByte;
      9'd2:    txByte = cfg.isLong ? 8'd0 : fetchByte;
      9'd3:    txByte = 8'd0;
      default: txByte = fetchByte;
    endcase
  end

  assign txLp = cfg.lowPower;

  // status
  logic doneAny;
  assign doneAny = stb.setWrDone | stb.setTrigDone | stb.setRdDone |
                   stb.setRdErr | stb.setAck | stb.setAckErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
    end else if (stb.beginCmd) begin
      status <= STATUS_W'(1);
    end else begin
      if (doneAny)         status[ST_BUSY]     <= 1'b0;
      if (stb.setWrDone)   status[ST_WR_DONE]  <= 1'b1;
      if (stb.setTrigDone) status[ST_TRG_DONE] <= 1'b1;
      if (stb.setRdDone)   status[ST_RD_DONE]  <= 1'b1;
      if (stb.setRdErr)    status[ST_RD_ERR]   <= 1'b1;
      if (stb.setAck)      status[ST_ACK]      <= 1'b1;
      if (stb.setAckErr)   status[ST_ACK_ERR]  <= 1'b1;
    end
  end

  // receive packing and FIFO
  logic [31:0]    rxMem [RX_WORDS];
  logic [31:0]    rxPart, rxMerged;
  logic [1:0]     rxLane;
  logic [RIW-1:0] rxWr, rxRd;
  logic [RCW-1:0] rxCount;
  logic           rxClose, rxCommit, rxPopOk;

  always_comb begin
    rxMerged = rxPart;
    rxMerged[{rxLane, 3'b000} +: 8] = rxByte;
    rxClose  = stb.rxTake && ((rxLane == 2'd3) || rxLast);
    rxCommit = rxClose && (rxCount != RX_FULL);
    rxPopOk  = rdPop && (rxCount != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.beginCmd) begin
      rxPart  <= '0;
      rxLane  <= '0;
      rxWr    <= '0;
      rxRd    <= '0;
      rxCount <= '0;
    end else begin
      if (stb.rxTake) begin
        rxPart <= rxClose ? 32'd0 : rxMerged;
        rxLane <= rxClose ? 2'd0 : rxLane + 2'd1;
      end
      if (rxCommit) rxWr <= (rxWr == RX_LAST) ? '0 : rxWr + 1'b1;
      if (rxPopOk)  rxRd <= (rxRd == RX_LAST) ? '0 : rxRd + 1'b1;
      if (rxCommit && !rxPopOk)      rxCount <= rxCount + 1'b1;
      else if (!rxCommit && rxPopOk) rxCount <= rxCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rxCommit) rxMem[rxWr] <= rxMerged;
  end

  assign rdWord      = rxMem[rxRd];
  assign rdWordValid = (rxCount != '0);

endmodule

// File: rtl/dsi_cmd_engine.sv
module dsi_cmd_engine
  import dsi_cmd_pkg::*;
#(
  parameter int DEPTH_CODE = 1,
  parameter int RX_WORDS   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [7:0]  txByte,
  output logic        txValid,
  input  logic        txReady,
  output logic        txLp,
  input  logic [7:0]  rxByte,
  input  logic        rxValid,
  input  logic        rxLast,
  input  logic        rxErr,
  output logic [10:0] status,
  output logic [31:0] rdWord,
  output logic        rdWordValid,
  input  logic        rdPop
);

  localparam int CMD_WORDS = 1 << DEPTH_CODE;
  localparam int CMD_BYTES = 4 * CMD_WORDS;

  cmdSettings_t cfg;
  ctlStrobe_t   stb;
  logic         sendReq;
  logic         busy;
  logic [8:0]   byteIdx;

  dsi_cmd_ctrl #(.CMD_BYTES(CMD_BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sendReq (sendReq),
    .cfgKind (cfg.kind),
    .cfgSize (cfg.size),
    .cfgLong (cfg.isLong),
    .txReady (txReady),
    .rxValid (rxValid),
    .rxLast  (rxLast),
    .rxErr   (rxErr),
    .stb     (stb),
    .txValid (txValid),
    .busy    (busy),
    .byteIdx (byteIdx)
  );

  dsi_cmd_datapath #(.CMD_WORDS(CMD_WORDS), .RX_WORDS(RX_WORDS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .busy        (busy),
    .byteIdx     (byteIdx),
    .stb         (stb),
    .rxByte      (rxByte),
    .rxLast      (rxLast),
    .rdPop       (rdPop),
    .cfg         (cfg),
    .sendReq     (sendReq),
    .txByte      (txByte),
    .txLp        (txLp),
    .status      (status),
    .rdWord      (rdWord),
    .rdWordValid (rdWordValid)
  );

endmodule

// File: rtl/dsi_cmd_engine_chk.sv
module dsi_cmd_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  txByte,
  input logic        txValid,
  input logic        txReady,
  input logic        txLp,
  input logic [10:0] status
);

  // R12: byte and low-power flag held while stalled
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte) && $stable(txLp)));

  // R5: a fresh busy flag comes with a byte on offer
  a_r5_start_tx: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> txValid);

  // R5: bytes only go out while busy
  a_r5_tx_busy: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> status[0]);

  // R6: leaving busy always leaves exactly one completion flag
  a_r6_done_flag: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> ($countones(status[10:1]) == 1));

  // R7: completion flags never overlap
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(status[10:1]));

endmodule

bind dsi_cmd_engine dsi_cmd_engine_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .txByte  (txByte),
  .txValid (txValid),
  .txReady (txReady),
  .txLp    (txLp),
  .status  (status)
);

// File: tb/dsi_cmd_engine_tb.sv
module dsi_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_WORDS  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWdata = 32'd0;
  logic [7:0] txByte;
  logic txValid, txLp;
  logic txReady = 1'b0;
  logic [7:0] rxByte = 8'd0;
  logic rxValid = 1'b0, rxLast = 1'b0, rxErr = 1'b0;
  logic [10:0] status;
  logic [31:0] rdWord;
  logic rdWordValid;
  logic rdPop = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsi_cmd_engine u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .txByte(txByte), .txValid(txValid), .txReady(txReady), .txLp(txLp),
    .rxByte(rxByte), .rxValid(rxValid), .rxLast(rxLast), .rxErr(rxErr),
    .status(status), .rdWord(rdWord), .rdWordValid(rdWordValid), .rdPop(rdPop)
  );

  int errors = 0;
  int checks = 0;

  logic [7:0] gotByte [0:4095];
  logic       gotLp   [0:4095];
  int gotN = 0;
  always @(posedge clk) begin
    if (rstN && txValid && txReady) begin
      gotByte[gotN] <= txByte;
      gotLp[gotN]   <= txLp;
      gotN          <= gotN + 1;
    end
  end

  logic stall = 1'b1;
  always @(negedge clk) txReady <= !stall && ($urandom_range(3) != 0);

  logic [31:0] pushed [0:CMD_WORDS-1];
  int pushedN = 0;
  logic [7:0] expB [0:300];
  int expN = 0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pushW(input logic [31:0] d, input logic modelIt);
    wr(2'd1, d);
    if (modelIt && pushedN < CMD_WORDS) begin
      pushed[pushedN] = d;
      pushedN++;
    end
  endtask

  task automatic flush();
    wr(2'd3, 32'd0);
    pushedN = 0;
  endtask

  function automatic logic [31:0] settingsWord(logic lp, logic [7:0] sz, logic [1:0] vc,
                                               logic [5:0] dt, logic lng, logic [2:0] kind);
    return {7'd0, lp, sz, vc, dt, 4'd0, lng, kind};
  endfunction

  function automatic logic [7:0] payB(int i);
    if (i / 4 < pushedN) return pushed[i/4][(i%4)*8 +: 8];
    return 8'd0;
  endfunction

  task automatic buildExp(logic [7:0] sz, logic [1:0] vc, logic [5:0] dt, logic lng);
    expB[0] = {vc, dt};
    expB[1] = lng ? sz : payB(0);
    expB[2] = lng ? 8'd0 : payB(1);
    expB[3] = 8'd0;
    expN = 4;
    if (lng) for (int i = 0; i < int'(sz); i++) begin
      expB[4+i] = payB(i);
      expN++;
    end
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (status[0] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, req, 32'(status), 32'd0);
  endtask

  task automatic waitTx(input int target, input string req);
    int n = 0;
    while (gotN < target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, req, 32'(gotN), 32'(target));
  endtask

  task automatic compareTx(input int base, input logic lp, input string req);
    int bad = -1;
    check((gotN - base) == expN, req, 32'(gotN - base), 32'(expN));
    for (int i = 0; i < expN; i++) begin
      if (bad < 0 && (gotByte[base+i] !== expB[i] || gotLp[base+i] !== lp)) bad = i;
    end
    if (bad >= 0) check(1'b0, req, {23'd0, gotLp[base+bad], gotByte[base+bad]}, {23'd0, lp, expB[bad]});
    else          check(1'b1, req, 32'd0, 32'd0);
  endtask

  task automatic rxSend(input int n, input logic [7:0] first, input logic err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxByte  = first + 8'(i);
      rxLast  = (i == n - 1);
      rxErr   = err && (i == n - 1);
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0; rxErr = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rdPop = 1'b1;
    @(negedge clk);
    rdPop = 1'b0;
  endtask

  // full write-style command: settings, send, wait, compare
  task automatic runWrite(logic lp, logic [7:0] sz, logic [1:0] vc, logic [5:0] dt,
                          logic lng, logic [2:0] kind, input string req);
    int base;
    wr(2'd0, settingsWord(lp, sz, vc, dt, lng, kind));
    buildExp(sz, vc, dt, lng);
    base = gotN;
    wr(2'd2, 32'd0);
    check(status[0] == 1'b1 && status[10:1] == 10'd0, "R5 busy after send", 32'(status), 32'd1);
    waitIdle(req);
    compareTx(base, lp, req);
    check(status == ((kind == 3'd0) ? 11'h002 : 11'h004), "R6 completion flag", 32'(status),
          (kind == 3'd0) ? 32'h002 : 32'h004);
    pushedN = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    int base;
    logic [10:0] prevStatus;
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status == 11'd0, "R1 status", 32'(status), 32'd0);
    check(!txValid && !rdWordValid, "R1 outputs idle", {30'd0, txValid, rdWordValid}, 32'd0);
    stall = 1'b0;

    // R3/R4: directed short and long writes
    flush();
    pushW(32'h44332211, 1'b1);
    runWrite(1'b1, 8'd2, 2'd2, 6'h15, 1'b0, 3'd0, "R3 short write header");
    flush();
    pushW(32'hDDCCBBAA, 1'b1);
    pushW(32'h00FFEE99, 1'b1);
    runWrite(1'b0, 8'd7, 2'd1, 6'h39, 1'b1, 3'd0, "R4 long write payload");
    flush();
    pushW(32'h87654321, 1'b1);
    runWrite(1'b1, 8'd6, 2'd3, 6'h29, 1'b1, 3'd0, "R4 unpushed bytes zero");
    runWrite(1'b0, 8'd0, 2'd0, 6'h35, 1'b0, 3'd5, "R6 trigger request");

    // R2/R12: constrained random mix of write, tearing-effect, trigger
    for (int it = 0; it < 30; it++) begin
      int np;
      logic [2:0] kind;
      flush();
      np = $urandom_range(3);
      for (int k = 0; k < np; k++) pushW($urandom, 1'b1);
      case ($urandom_range(2))
        0: kind = 3'd0;
        1: kind = 3'd4;
        default: kind = 3'd5;
      endcase
      runWrite(1'($urandom), 8'($urandom_range(8)), 2'($urandom), 6'($urandom),
               1'($urandom), kind, "R2 random command R12");
    end

    // R9: rejected sends
    prevStatus = status;
    flush();
    pushW(32'h01020304, 1'b1);
    foreach (expB[i]) if (i < 1) expB[i] = 8'd0;
    wr(2'd0, settingsWord(1'b0, 8'd9, 2'd0, 6'h39, 1'b1, 3'd0));
    base = gotN;
    wr(2'd2, 32'd0);
    repeat (5) @(negedge clk);
    check(status == prevStatus && gotN == base, "R9 oversize rejected", 32'(status), 32'(prevStatus));
    wr(2'd0, settingsWord(1'b0, 8'd3, 2'd0, 6'h14, 1'b0, 3'd1));
    wr(2'd2, 32'd0);
    repeat (5) @(negedge clk);
    check(status == prevStatus && gotN == base, "R9 read payload >2 rejected", 32'(status), 32'(prevStatus));
    wr(2'd0, settingsWord(1'b0, 8'd1, 2'd0, 6'h05, 1'b0, 3'd3));
    wr(2'd2, 32'd0);
    repeat (5) @(negedge clk);
    check(status == prevStatus && gotN == base, "R9 unused kind rejected", 32'(status), 32'(prevStatus));
    // FIFO kept its word after rejections
    runWrite(1'b0, 8'd4, 2'd1, 6'h29, 1'b1, 3'd0, "R9 fifo kept after reject");

    // R10: writes while busy ignored
    flush();
    pushW(32'h13579BDF, 1'b1);
    pushW(32'h2468ACE0, 1'b1);
    stall = 1'b1;
    wr(2'd0, settingsWord(1'b1, 8'd8, 2'd2, 6'h39, 1'b1, 3'd0));
    buildExp(8'd8, 2'd2, 6'h39, 1'b1);
    base = gotN;
    wr(2'd2, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd0, settingsWord(1'b0, 8'd1, 2'd0, 6'h05, 1'b0, 3'd5));
    wr(2'd1, 32'hFFFFFFFF);
    wr(2'd3, 32'd0);
    stall = 1'b0;
    waitIdle("R10 busy command finishes");
    compareTx(base, 1'b1, "R10 busy writes ignored");
    pushedN = 0;
    buildExp(8'd8, 2'd2, 6'h39, 1'b1);
    base = gotN;
    wr(2'd2, 32'd0);
    waitIdle("R10 resend");
    compareTx(base, 1'b1, "R10 settings kept and R11 fifo emptied by send");

    // R11: flush and overflow
    flush();
    pushW(32'hAAAAAAAA, 1'b0);
    pushW(32'hBBBBBBBB, 1'b0);
    flush();
    runWrite(1'b0, 8'd8, 2'd0, 6'h39, 1'b1, 3'd0, "R11 flush empties fifo");
    flush();
    pushW(32'h11111111, 1'b1);
    pushW(32'h22222222, 1'b1);
    pushW(32'h33333333, 1'b1);
    runWrite(1'b0, 8'd8, 2'd0, 6'h39, 1'b1, 3'd0, "R11 overflow push dropped");

    // R7: read with partial word
    flush();
    pushW(32'h00003412, 1'b1);
    wr(2'd0, settingsWord(1'b1, 8'd2, 2'd1, 6'h06, 1'b0, 3'd1));
    buildExp(8'd2, 2'd1, 6'h06, 1'b0);
    base = gotN;
    wr(2'd2, 32'd0);
    waitTx(base + 4, "R7 read request sent");
    compareTx(base, 1'b1, "R7 read header");
    check(status == 11'h001, "R7 busy awaiting reply", 32'(status), 32'h001);
    rxSend(5, 8'hA0, 1'b0);
    waitIdle("R7 read finishes");
    check(status == 11'h008, "R7 read completed", 32'(status), 32'h008);
    check(rdWordValid && rdWord == 32'hA3A2A1A0, "R7 first word", rdWord, 32'hA3A2A1A0);
    pop();
    check(rdWordValid && rdWord == 32'h000000A4, "R7 partial word", rdWord, 32'h000000A4);
    pop();
    check(!rdWordValid, "R7 fifo drained", 32'(rdWordValid), 32'd0);

    // R7: read error and overflow
    flush();
    wr(2'd0, settingsWord(1'b0, 8'd0, 2'd0, 6'h06, 1'b0, 3'd1));
    base = gotN;
    wr(2'd2, 32'd0);
    waitTx(base + 4, "R7 read2 sent");
    rxSend(10, 8'h10, 1'b1);
    waitIdle("R7 read2 finishes");
    check(status == 11'h400, "R7 read with error", 32'(status), 32'h400);
    check(rdWordValid && rdWord == 32'h13121110, "R7 overflow word0", rdWord, 32'h13121110);
    pop();
    check(rdWordValid && rdWord == 32'h17161514, "R7 overflow word1", rdWord, 32'h17161514);
    pop();
    check(!rdWordValid, "R7 extra word dropped", 32'(rdWordValid), 32'd0);

    // R8: acknowledge requests
    for (int e = 0; e < 2; e++) begin
      wr(2'd0, settingsWord(1'b1, 8'd0, 2'd3, 6'h05, 1'b0, 3'd6));
      base = gotN;
      wr(2'd2, 32'd0);
      waitTx(base + 4, "R8 ack request sent");
      rxSend(1, 8'h55, 1'(e));
      waitIdle("R8 ack finishes");
      check(status == ((e == 1) ? 11'h020 : 11'h010), "R8 ack flag", 32'(status),
            (e == 1) ? 32'h020 : 32'h010);
      check(!rdWordValid, "R8 no reply data stored", 32'(rdWordValid), 32'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule